// File: doc/BRIEF.md
# Interrupt status and mask controller

This block gathers interrupt requests from up to sixteen peripherals into one status register and gates it with a mask register. It drives a single combined interrupt line to the processor. A rising edge on a request input latches the matching status bit, so each request input can be a pulse or a level.

Software reads both registers over a small register bus. It acknowledges interrupts by writing the status register with an AND: a bit written as 0 is cleared and a bit written as 1 is left as it was. Request input 3 carries the DMA controller's interrupt and lands in status bit 3. Priority encoding and vectoring are left to the processor side.

Top module: `ictl_top`

## Requirements
- R1: After reset the status and mask registers read zero and `cpu_irq` is low.
- R2: A 0-to-1 transition on `irq_req[i]` sets status bit i at the next clock edge. A request held high sets the bit only once, so after it is acknowledged the bit stays clear until a new rising edge arrives.
- R3: A write to the status register (offset 0x070) leaves status equal to the old status AND the low 16 bits of the write data.
- R4: If a rising edge and an acknowledge (a 0 written to that bit) hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to the mask register (offset 0x074) stores the low 16 bits of the write data and changes no status bit.
- R6: `cpu_irq` is high exactly when (status AND mask) is nonzero. It follows the registers, so after a write or a captured edge it is correct in the cycle after the clock edge.
- R7: Reads of offset 0x070 or 0x074 return the 16-bit register value with bits 31:16 zero. Reads of any other offset return zero, and writes to any other offset change neither register.
- R8: Request input i maps to status bit i. Input 3 is the DMA controller's request and is reported in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register offset within the I/O window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_req | input | 16 | Peripheral interrupt requests |
| cpu_irq | output | 1 | Combined interrupt line to the processor |

## Verification
The bench builds the block with its default parameters: sixteen sources, a 12-bit offset and a 32-bit data bus. With these values the edge sources at bit 0 and bit 15 can be driven, as can the DMA bit 3. The upper half of the data word, which must be dropped on writes and read back as zero, is also reachable. The run also reaches the cycle in which a new edge and an acknowledge of the same bit collide, and a level request held across its own acknowledge.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
    localparam int unsigned DEF_SRC    = 16;
    localparam int unsigned DEF_ADDR_W = 12;
    localparam int unsigned DEF_DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/ictl_edge.sv
module ictl_edge #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] rise
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_rise
        assign rise[i] = req[i] & ~st_q.prev[i];
    end
endmodule

// File: rtl/ictl_regs.sv
module ictl_regs #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stat,
    input  logic               wr_mask,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] rise,
    output logic [NUM_SRC-1:0] stat,
    output logic [NUM_SRC-1:0] mask
);
    typedef struct packed {
        logic [NUM_SRC-1:0] stat;
        logic [NUM_SRC-1:0] mask;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        logic [NUM_SRC-1:0] keep;
        st_d = st_q;
        keep = wr_stat ? wdata : '1;
        // acknowledge first, then new edges, so a same-cycle set survives
        st_d.stat = (st_q.stat & keep) | rise;
        if (wr_mask) st_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign mask = st_q.mask;

    // R2
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((stat & $past(rise)) == $past(rise)));

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat & ~$past(wdata) & ~$past(rise)) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (|(rise & ~wdata))) |=> ((stat & $past(rise & ~wdata)) == $past(rise & ~wdata)));

    // R5
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask == $past(wdata)));

    // R5
    mask_keeps_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && !wr_stat) |=> (stat == ($past(stat) | $past(rise))));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask));
endmodule

// File: rtl/ictl_top.sv
module ictl_top
    import ictl_pkg::*;
#(
    parameter int unsigned NUM_SRC  = DEF_SRC,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    output logic              cpu_irq
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] rise, stat, mask;

    always_comb begin
        if (bus_addr == STAT_OFS)      sel = SEL_STAT;
        else if (bus_addr == MASK_OFS) sel = SEL_MASK;
        else                           sel = SEL_NONE;
    end

    ictl_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (irq_req),
        .rise (rise)
    );

    ictl_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stat(bus_we && sel == SEL_STAT),
        .wr_mask(bus_we && sel == SEL_MASK),
        .wdata  (bus_wdata[NUM_SRC-1:0]),
        .rise   (rise),
        .stat   (stat),
        .mask   (mask)
    );

    always_comb begin
        case (sel)
            SEL_STAT: bus_rdata = {{PAD_W{1'b0}}, stat};
            SEL_MASK: bus_rdata = {{PAD_W{1'b0}}, mask};
            default:  bus_rdata = '0;
        endcase
    end

    assign cpu_irq = |(stat & mask);

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_we) && $stable(stat)) |-> (cpu_irq == $past(cpu_irq) || $changed(mask)));
endmodule

// File: tb/ictl_top_tb.sv
module ictl_top_tb;
    localparam logic [11:0] A_STAT  = 12'h070;
    localparam logic [11:0] A_MASK  = 12'h074;
    localparam logic [11:0] A_OTHER = 12'h078;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_req = '0;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ictl_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .cpu_irq(cpu_irq)
    );

    // monitor: compares each queued expectation at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (bus_rdata !== e.rd || cpu_irq !== e.irq) begin
                errors++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, bus_rdata, cpu_irq, e.rd, e.irq);
            end
        end
    end

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] v,
                             input logic irq, input string tag);
        exp_t e;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = a;
        e.rd = v; e.irq = irq; e.tag = tag;
        q.push_back(e);
        @(negedge clk); #0.1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(posedge clk); #1; irq_req[i] = 1'b1;
        @(posedge clk); #1; irq_req[i] = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        expect_rd(A_STAT, 32'h0, 1'b0, "R1 status after reset");
        expect_rd(A_MASK, 32'h0, 1'b0, "R1 mask after reset");
        // R8 / R2: DMA source pulse sets bit 3, masked so no irq
        pulse(3);
        expect_rd(A_STAT, 32'h0008, 1'b0, "R8 R2 DMA bit 3 set");
        // R5 mask write, status untouched; R6 irq rises
        wr(A_MASK, 32'h0008);
        expect_rd(A_MASK, 32'h0008, 1'b1, "R5 mask stored");
        expect_rd(A_STAT, 32'h0008, 1'b1, "R5 status untouched R6 irq");
        // R2 edge bits 0 and 15
        pulse(0);
        pulse(15);
        expect_rd(A_STAT, 32'h8009, 1'b1, "R2 bits 0 and 15");
        // R3 AND acknowledge
        wr(A_STAT, 32'h0000_FFF7);
        expect_rd(A_STAT, 32'h8001, 1'b0, "R3 ack bit 3 R6 irq low");
        wr(A_MASK, 32'h8000);
        expect_rd(A_STAT, 32'h8001, 1'b1, "R6 irq from bit 15");
        // R2 level held across its acknowledge
        @(posedge clk); #1 irq_req[5] = 1'b1;
        expect_rd(A_STAT, 32'h8021, 1'b1, "R2 level sets once");
        wr(A_STAT, 32'h0000_FFDF);
        expect_rd(A_STAT, 32'h8001, 1'b1, "R2 held level no re-set");
        @(posedge clk); #1 irq_req[5] = 1'b0;
        // R4 set wins over same-cycle ack
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0; irq_req[7] = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; irq_req[7] = 1'b0;
        expect_rd(A_STAT, 32'h0080, 1'b0, "R4 set wins");
        // R7 other offset ignored and reads zero
        wr(A_OTHER, 32'hFFFF_FFFF);
        expect_rd(A_OTHER, 32'h0, 1'b0, "R7 other offset reads zero");
        expect_rd(A_STAT, 32'h0080, 1'b0, "R7 status after stray write");
        expect_rd(A_MASK, 32'h8000, 1'b0, "R7 mask after stray write");
        // R7 upper bits dropped, zero-extended read
        wr(A_MASK, 32'hFFFF_0080);
        expect_rd(A_MASK, 32'h0000_0080, 1'b1, "R7 zero-extended mask");
        wr(A_STAT, 32'hFFFF_0000);
        expect_rd(A_STAT, 32'h0, 1'b0, "R3 full clear");
        // R1 reset mid-run
        pulse(2);
        wr(A_MASK, 32'h0004);
        expect_rd(A_STAT, 32'h0004, 1'b1, "R6 irq before reset");
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        expect_rd(A_STAT, 32'h0, 1'b0, "R1 status after second reset");
        expect_rd(A_MASK, 32'h0, 1'b0, "R1 mask after second reset");
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule